// File: doc/BRIEF.md
# I2C Bus Hang Recovery Controller

When a bus master is reset part-way through a read, a peripheral may still be shifting out a data bit and keep SDA pulled low indefinitely. This controller clears that condition before the normal I2C controller is brought up. A single-cycle start launches a sequence. The block first leaves SCL released for one half period and then samples SDA. If SDA is low, the block keeps issuing low-then-high clock pulses on SCL, checking SDA after each one. It stops when SDA is seen high or when a programmed pulse limit has been used up.

SCL is open-drain. The block only asserts a pull-down enable and never drives the line high. It has no connection to SDA other than an input, which goes through a two-flop synchronizer. When a sequence ends, a one-cycle done pulse is produced along with a held result code. The code tells the caller whether the bus was idle, whether it was recovered, or whether it is still stuck. A typical setup uses a limit of 15 pulses and a half period of one half of a 100 kHz bit time.

Top module: `i2c_unstick`

## Requirements
- R1: In the cycle after a start is accepted, busy_o rises. SCL stays released for one half period before the first SDA sample, so a run with P pulses keeps busy_o high for exactly H*(2P+1) cycles, where H is the half-period length.
- R2: Each half period, low or high, lasts exactly half_div_i clock cycles. The value is captured at start, and a value of 0 is treated as 1.
- R3: If SDA is high at the first sample, the run ends with no SCL pulse and result_o = 2'b00 (bus was not hung).
- R4: If SDA is seen high after one or more pulses, the run stops at once with result_o = 2'b01 (recovered). The number of pulses equals the number the peripheral needed.
- R5: If SDA is still low after max_pulses_i pulses, the run ends with result_o = 2'b10 (still hung) and no further pulse.
- R6: With max_pulses_i = 0, no pulse is issued. The result is 2'b10 if SDA is low and 2'b00 if SDA is high.
- R7: scl_pull_o is asserted only during low half periods of a run and never while idle.
- R8: SDA is sampled through a two-stage synchronizer at the last cycle of a high half period. A release arriving at the start of a two-cycle high phase is therefore seen only after the next pulse.
- R9: Start is ignored while busy_o is high. The run's parameters and outcome are unaffected, and no second run follows.
- R10: done_o is high for one cycle, in the same cycle busy_o falls. result_o keeps its value until the next accepted start.
- R11: After reset, busy_o, done_o and scl_pull_o are low and result_o is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch a recovery run (accepted only when idle) |
| half_div_i | input | DIV_W | Half-period length in clock cycles |
| max_pulses_i | input | CNT_W | Maximum number of SCL pulses |
| sda_i | input | 1 | SDA line level (asynchronous) |
| scl_pull_o | output | 1 | Pull-down enable for SCL |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| result_o | output | 2 | 00 not hung, 01 recovered, 10 still hung |

## Verification
The hardest case to reach is a release that arrives just before a sample point, so that it falls within the synchronizer delay. From the ports this cannot be timed directly. The bench therefore models the peripheral: it lets go of SDA right after a chosen number of SCL rising edges. With a two-cycle half period, the release misses the sample that follows, and the test expects exactly one extra pulse. The same peripheral model covers release counts of 0, 1, 9, 12 and the limit, a peripheral that never releases, a zero limit, and a start pulse injected in the middle of a run.

// File: rtl/unstick_pkg.sv
package unstick_pkg;
    typedef enum logic [1:0] {
        RES_CLEAR = 2'b00,
        RES_FREED = 2'b01,
        RES_STUCK = 2'b10
    } res_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HIGH,
        ST_LOW
    } st_e;
endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign chain_d[i] = d_i;
            end else begin : g_next
                assign chain_d[i] = chain_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/unstick_timer.sv
module unstick_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             reload_i,
    input  logic [DIV_W-1:0] len_i,
    output logic             expire_o
);
    typedef struct packed {
        logic [DIV_W-1:0] len;
        logic [DIV_W-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;
    logic [DIV_W-1:0] len_eff;

    always_comb begin
        s_d     = s_q;
        len_eff = (len_i == '0) ? DIV_W'(1) : len_i;
        if (arm_i) begin
            s_d.len = len_eff;
            s_d.cnt = len_eff - DIV_W'(1);
        end else if (reload_i) begin
            s_d.cnt = s_q.len - DIV_W'(1);
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign expire_o = (s_q.cnt == '0);
endmodule

// File: rtl/unstick_ctrl.sv
module unstick_ctrl
    import unstick_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] max_pulses_i,
    input  logic             sda_s_i,
    input  logic             expire_i,
    output logic             arm_o,
    output logic             reload_o,
    output logic             scl_pull_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [1:0]       result_o
);
    typedef struct packed {
        st_e              st;
        logic [CNT_W-1:0] pulses;
        logic [CNT_W-1:0] limit;
        logic             hung;
        logic             done;
        res_e             result;
    } ctl_t;

    ctl_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        arm_o    = 1'b0;
        reload_o = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st     = ST_HIGH;
                    s_d.limit  = max_pulses_i;
                    s_d.pulses = '0;
                    s_d.hung   = 1'b0;
                    arm_o      = 1'b1;
                end
            end
            ST_HIGH: begin
                if (expire_i) begin
                    if (sda_s_i) begin
                        s_d.st     = ST_IDLE;
                        s_d.done   = 1'b1;
                        s_d.result = s_q.hung ? RES_FREED : RES_CLEAR;
                    end else if (s_q.pulses == s_q.limit) begin
                        s_d.st     = ST_IDLE;
                        s_d.done   = 1'b1;
                        s_d.result = RES_STUCK;
                    end else begin
                        s_d.hung = 1'b1;
                        s_d.st   = ST_LOW;
                        reload_o = 1'b1;
                    end
                end
            end
            ST_LOW: begin
                if (expire_i) begin
                    s_d.pulses = s_q.pulses + CNT_W'(1);
                    s_d.st     = ST_HIGH;
                    reload_o   = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st     <= ST_IDLE;
            s_q.pulses <= '0;
            s_q.limit  <= '0;
            s_q.hung   <= 1'b0;
            s_q.done   <= 1'b0;
            s_q.result <= RES_CLEAR;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_pull_o = (s_q.st == ST_LOW);
    assign busy_o     = (s_q.st != ST_IDLE);
    assign done_o     = s_q.done;
    assign result_o   = s_q.result;
endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick #(
    parameter int DIV_W = 16,
    parameter int CNT_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DIV_W-1:0] half_div_i,
    input  logic [CNT_W-1:0] max_pulses_i,
    input  logic             sda_i,
    output logic             scl_pull_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [1:0]       result_o
);
    logic sda_s, expire, arm, reload;

    unstick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sda_i),
        .q_o   (sda_s)
    );

    unstick_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (arm),
        .reload_i (reload),
        .len_i    (half_div_i),
        .expire_o (expire)
    );

    unstick_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .max_pulses_i (max_pulses_i),
        .sda_s_i      (sda_s),
        .expire_i     (expire),
        .arm_o        (arm),
        .reload_o     (reload),
        .scl_pull_o   (scl_pull_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .result_o     (result_o)
    );
endmodule

// File: rtl/unstick_check.sv
module unstick_check (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_pull_o,
    input logic       busy_o,
    input logic       done_o,
    input logic [1:0] result_o
);
    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_done_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r10_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    a_r7_pull_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull_o |-> busy_o);

    a_r9_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));

    always @(posedge clk) begin
        if (rst_n) begin
            a_r3_code_legal: assert (result_o != 2'b11);
        end
    end
endmodule

bind i2c_unstick unstick_check u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_pull_o (scl_pull_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o)
);

// File: tb/tb_i2c_unstick.sv
module tb_i2c_unstick;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] half = 16'd4;
    logic [7:0]  maxp = 8'd15;
    logic        sda = 1'b1;
    logic        scl_pull, busy, done;
    logic [1:0]  result;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    i2c_unstick dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .half_div_i   (half),
        .max_pulses_i (maxp),
        .sda_i        (sda),
        .scl_pull_o   (scl_pull),
        .busy_o       (busy),
        .done_o       (done),
        .result_o     (result)
    );

    // half, max pulses, pulses the peripheral needs, expected code, expected pulses
    localparam int NV = 11;
    localparam int VEC [NV][5] = '{
        '{4, 15,   0, 0,  0},
        '{4, 15,   1, 1,  1},
        '{5, 15,   9, 1,  9},
        '{4, 15,  12, 1, 12},
        '{6, 15,  15, 1, 15},
        '{4, 15,  16, 2, 15},
        '{4,  3, 255, 2,  3},
        '{4,  0,   5, 2,  0},
        '{4,  0,   0, 0,  0},
        '{7,  9,   9, 1,  9},
        '{3, 20,   4, 1,  4}
    };

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Peripheral model: holds SDA low until it has seen k SCL rising edges.
    task automatic run(int h, int mx, int k, int poke,
                       output int pulses, output int busy_cyc,
                       output int res, output int dones, output int low_cyc);
        bit prev_pull;
        @(negedge clk);
        sda = (k == 0);
        half = 16'(h);
        maxp = 8'(mx);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        pulses = 0; busy_cyc = 0; res = -1; dones = 0; low_cyc = 0;
        prev_pull = 1'b0;
        for (int it = 0; it < 20000; it++) begin
            start = (it == poke);
            if (it == poke) maxp = 8'd0;
            if (busy) busy_cyc++;
            if (scl_pull) low_cyc++;
            if (prev_pull && !scl_pull) begin
                pulses++;
                if (pulses >= k) sda = 1'b1;
            end
            prev_pull = scl_pull;
            if (done) begin
                dones++;
                res = int'(result);
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        int p, bc, r, dn, lc, h;
        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11 busy", int'(busy), 0);
        chk("R11 done", int'(done), 0);
        chk("R11 pull", int'(scl_pull), 0);
        chk("R11 result", int'(result), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table: R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            h = VEC[v][0];
            run(h, VEC[v][1], VEC[v][2], -1, p, bc, r, dn, lc);
            chk($sformatf("R3/R4/R5 code vec%0d", v), r, VEC[v][3]);
            chk($sformatf("R4/R5/R6 pulses vec%0d", v), p, VEC[v][4]);
            chk($sformatf("R1 busy cycles vec%0d", v), bc, h * (2 * VEC[v][4] + 1));
            chk($sformatf("R2 R7 low cycles vec%0d", v), lc, h * VEC[v][4]);
            chk($sformatf("R10 one done vec%0d", v), dn, 1);
        end

        // R8: two-cycle half period, release right after pulse 1 is missed
        run(2, 15, 1, -1, p, bc, r, dn, lc);
        chk("R8 code", r, 1);
        chk("R8 pulses", p, 2);
        chk("R8 busy cycles", bc, 10);

        // R2: half_div of zero behaves as one cycle
        run(0, 15, 0, -1, p, bc, r, dn, lc);
        chk("R2 zero div busy", bc, 1);
        chk("R2 zero div code", r, 0);

        // R9: start pulse mid-run (with max changed to 0) is ignored
        run(4, 15, 3, 7, p, bc, r, dn, lc);
        chk("R9 code", r, 1);
        chk("R9 pulses", p, 3);
        chk("R9 busy cycles", bc, 28);
        begin
            int extra = 0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (busy || scl_pull || done) extra++;
            end
            chk("R9 no second run", extra, 0);
        end

        // R10: result held while idle, then replaced by next run
        run(4, 2, 255, -1, p, bc, r, dn, lc);
        repeat (20) @(negedge clk);
        chk("R10 result holds", int'(result), 2);
        chk("R10 done low idle", int'(done), 0);
        run(4, 2, 0, -1, p, bc, r, dn, lc);
        chk("R10 result replaced", r, 0);

        report();
    end
endmodule